// File: doc/BRIEF.md
# Transfer-to-Descriptor Splitter

This block turns one transfer request into the ordered list of DMA commands that cover it. A request gives a memory address, a byte count, a fixed peripheral address, a direction, a burst size, a flow-control enable, a channel number for the flow-control handshake and a flag that marks the request as the final segment of a larger transaction. The block emits one complete command per cycle on a valid/ready stream, so a downstream writer can store each command into a command list in memory.

With flow control enabled, the block covers the bytes with two-dimensional box commands made of whole bursts. Each box holds up to 65535 rows. Any tail shorter than one burst goes out as one single command. With flow control disabled, the block emits plain single commands of at most 65535 bytes each. A request with an unusable burst size or channel number is refused with an error pulse. Every accepted request ends with a done pulse that reports how many box and single commands were produced and which block-size code applies.

The controller is a four-state machine. ST_IDLE accepts a request and has three exits: to ST_FAIL when validation refuses it, to ST_DONE for a flow-controlled request of zero bytes, and to ST_EMIT otherwise. ST_EMIT presents a command and stays in ST_EMIT after each handshake until the final command is accepted, then moves to ST_DONE. ST_FAIL and ST_DONE each last one cycle and return to ST_IDLE.

Top module: `xfer_splitter`

## Requirements
- R1: With flow control on, a burst size other than 16, 32, 64, 128, 192 or 256 is refused. err_pulse is high for exactly the one cycle after acceptance, and neither a command nor done_pulse follows. With flow control off, the burst size is not checked.
- R2: With flow control on, a channel number whose low four bits are zero, or whose value exceeds 31, is refused in the same way as R1.
- R3: With flow control on, a box command (cmd_box=1, cmd_word[1:0]=3) is emitted while the remaining count is at least one burst. Its row count is min(remaining/burst, 65535). cmd_rows carries that count in bits 31:16 and again in bits 15:0. cmd_len carries the burst size in both halves.
- R4: The box row offset (cmd_rowoff) is the burst size in bits 15:0 for peripheral-to-memory transfers (req_m2p=0), and the burst size in bits 31:16 for memory-to-peripheral transfers.
- R5: With flow control on, a tail shorter than one burst produces one single command (cmd_box=0, cmd_word[1:0]=0) of that length, with cmd_rows and cmd_rowoff zero. A zero-byte flow-controlled request emits nothing and reports done with zero counts.
- R6: With flow control off, single commands of length min(remaining, 65535) are emitted until nothing remains. A zero-byte request emits one single command of length 0.
- R7: For peripheral-to-memory transfers, cmd_src is the peripheral address and cmd_dst is the memory address. For memory-to-peripheral transfers they are swapped. The memory address advances by the bytes each command covers, and the peripheral address never changes.
- R8: With flow control on, the low four bits of the channel number sit in cmd_word[6:3] for peripheral-to-memory transfers and in cmd_word[10:7] for memory-to-peripheral transfers. With flow control off, both fields are zero.
- R9: cmd_word[31] is set only on the final command of a request whose req_last is set.
- R10: done_pulse is high for one cycle after the final command handshake. During that cycle, done_boxes and done_singles give the command counts, and done_blk gives the block-size code (16→0, 32→1, 64→2, 128→3, 192→4, 256→5, and 0 with flow control off).
- R11: While cmd_valid is high and cmd_ready is low, all command outputs hold steady. req_ready is high only when the block is idle.
- R12: After reset, req_ready is 1 and cmd_valid, err_pulse and done_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_mem_addr | input | ADDR_W | Memory start address |
| req_periph_addr | input | ADDR_W | Fixed peripheral address |
| req_len | input | LEN_W | Byte count |
| req_m2p | input | 1 | 1 memory-to-peripheral, 0 peripheral-to-memory |
| req_burst | input | 9 | Burst size in bytes |
| req_fc | input | 1 | Flow control enable |
| req_chan | input | CHAN_W | Flow-control channel number |
| req_last | input | 1 | Final segment of the transaction |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken |
| cmd_box | output | 1 | 1 box command, 0 single command |
| cmd_word | output | 32 | Control word: type, channel field, last bit |
| cmd_src | output | ADDR_W | Source address |
| cmd_dst | output | ADDR_W | Destination address |
| cmd_len | output | 32 | Single length, or box row length in both halves |
| cmd_rows | output | 32 | Box row count in both halves |
| cmd_rowoff | output | 32 | Box row offset |
| err_pulse | output | 1 | Request refused |
| done_pulse | output | 1 | Request finished |
| done_boxes | output | CNT_W | Box commands produced |
| done_singles | output | CNT_W | Single commands produced |
| done_blk | output | 3 | Block-size code |

## Verification
Requests are tried in both directions across several burst sizes, so the direction-dependent fields can be told apart: stride half, channel field position and source/destination swap. Byte counts are chosen as exact multiples of a burst, as multiples with a tail, and as a count larger than the 65535-row cap. This separates the box-only, box-plus-single and capped-box paths, and with flow control off it also separates capped from uncapped singles. Zero-length requests in both modes exercise the edge where one mode emits a command and the other emits none. Refused requests cover a bad burst, channel zero, a channel with a zero low nibble, and a channel above 31, next to accepted neighbours. The output is stalled in an irregular pattern so that holding under back-pressure is compared on every cycle.

// File: rtl/xs_pkg.sv
package xs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_FAIL = 2'd2,
        ST_DONE = 2'd3
    } xs_state_e;

    localparam logic [1:0] TYPE_SINGLE = 2'd0;
    localparam logic [1:0] TYPE_BOX    = 2'd3;
    localparam int         LAST_BIT    = 31;

endpackage

// File: rtl/xs_check.sv
module xs_check #(
    parameter int CHAN_W = 6
) (
    input  logic              fc_en,
    input  logic [8:0]        burst,
    input  logic [CHAN_W-1:0] chan,
    output logic              ok,
    output logic [2:0]        blk_code
);
    logic       burst_ok;
    logic       chan_ok;
    logic [2:0] code;

    always_comb begin
        burst_ok = 1'b1;
        code     = 3'd0;
        unique case (burst)
            9'd16:   code = 3'd0;
            9'd32:   code = 3'd1;
            9'd64:   code = 3'd2;
            9'd128:  code = 3'd3;
            9'd192:  code = 3'd4;
            9'd256:  code = 3'd5;
            default: burst_ok = 1'b0;
        endcase
    end

    assign chan_ok  = (chan[3:0] != 4'd0) && (chan <= CHAN_W'(31));
    assign ok       = !fc_en || (burst_ok && chan_ok);
    assign blk_code = fc_en ? code : 3'd0;

endmodule

// File: rtl/xs_cmd_gen.sv
module xs_cmd_gen #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 24,
    parameter int MAX_CNT = 65535,
    parameter int CNT_W   = 16
) (
    input  logic [LEN_W-1:0]  rem,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] periph_addr,
    input  logic              m2p,
    input  logic              fc_en,
    input  logic [8:0]        burst,
    input  logic [2:0]        blk_code,
    input  logic [3:0]        chan,
    input  logic              seg_last,
    output logic              is_box,
    output logic [31:0]       word,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [31:0]       len_f,
    output logic [31:0]       rows_f,
    output logic [31:0]       off_f,
    output logic [LEN_W-1:0]  consumed,
    output logic              final_cmd
);
    import xs_pkg::*;

    localparam int PROD_W = LEN_W + 9;
    localparam int ROW_W  = 16;

    logic [LEN_W-1:0]  rows_raw;
    logic [ROW_W-1:0]  rows;
    logic [PROD_W-1:0] prod;
    logic [LEN_W-1:0]  single_len;
    logic [LEN_W-1:0]  rem_after;

    always_comb begin
        unique case (blk_code)
            3'd0:    rows_raw = rem >> 4;
            3'd1:    rows_raw = rem >> 5;
            3'd2:    rows_raw = rem >> 6;
            3'd3:    rows_raw = rem >> 7;
            3'd4:    rows_raw = (rem >> 6) / LEN_W'(3);
            default: rows_raw = rem >> 8;
        endcase
    end

    assign rows = (rows_raw > LEN_W'(MAX_CNT)) ? ROW_W'(MAX_CNT) : rows_raw[ROW_W-1:0];
    assign prod = PROD_W'(rows) * PROD_W'(burst);

    assign is_box     = fc_en && (rem >= LEN_W'(burst));
    assign single_len = (!fc_en && (rem > LEN_W'(MAX_CNT))) ? LEN_W'(MAX_CNT) : rem;
    assign consumed   = is_box ? prod[LEN_W-1:0] : single_len;
    assign rem_after  = rem - consumed;
    assign final_cmd  = (rem_after == '0);

    assign src = m2p ? mem_addr : periph_addr;
    assign dst = m2p ? periph_addr : mem_addr;

    always_comb begin
        word = '0;
        word[1:0] = is_box ? TYPE_BOX : TYPE_SINGLE;
        if (fc_en) begin
            if (m2p) word[10:7] = chan;
            else     word[6:3]  = chan;
        end
        word[LAST_BIT] = seg_last && final_cmd;
    end

    always_comb begin
        if (is_box) begin
            len_f  = {16'(burst), 16'(burst)};
            rows_f = {16'(rows), 16'(rows)};
            off_f  = m2p ? {16'(burst), 16'h0} : {16'h0, 16'(burst)};
        end else begin
            len_f  = 32'(single_len);
            rows_f = '0;
            off_f  = '0;
        end
    end

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 24,
    parameter int CHAN_W  = 6,
    parameter int MAX_CNT = 65535,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_mem_addr,
    input  logic [ADDR_W-1:0] req_periph_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_m2p,
    input  logic [8:0]        req_burst,
    input  logic              req_fc,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_last,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_box,
    output logic [31:0]       cmd_word,
    output logic [ADDR_W-1:0] cmd_src,
    output logic [ADDR_W-1:0] cmd_dst,
    output logic [31:0]       cmd_len,
    output logic [31:0]       cmd_rows,
    output logic [31:0]       cmd_rowoff,
    output logic              err_pulse,
    output logic              done_pulse,
    output logic [CNT_W-1:0]  done_boxes,
    output logic [CNT_W-1:0]  done_singles,
    output logic [2:0]        done_blk
);
    import xs_pkg::*;

    xs_state_e state_q, state_d;

    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] mem_q;
    logic [ADDR_W-1:0] per_q;
    logic              m2p_q;
    logic              fc_q;
    logic [8:0]        burst_q;
    logic [3:0]        chan_q;
    logic              last_q;
    logic [2:0]        blk_q;
    logic [CNT_W-1:0]  boxes_q;
    logic [CNT_W-1:0]  singles_q;

    logic              req_ok;
    logic [2:0]        req_blk;
    logic              accept;
    logic              fire;
    logic              gen_box;
    logic [LEN_W-1:0]  gen_consumed;
    logic              gen_final;

    xs_check #(.CHAN_W(CHAN_W)) u_check (
        .fc_en    (req_fc),
        .burst    (req_burst),
        .chan     (req_chan),
        .ok       (req_ok),
        .blk_code (req_blk)
    );

    xs_cmd_gen #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .MAX_CNT (MAX_CNT),
        .CNT_W   (CNT_W)
    ) u_gen (
        .rem         (rem_q),
        .mem_addr    (mem_q),
        .periph_addr (per_q),
        .m2p         (m2p_q),
        .fc_en       (fc_q),
        .burst       (burst_q),
        .blk_code    (blk_q),
        .chan        (chan_q),
        .seg_last    (last_q),
        .is_box      (gen_box),
        .word        (cmd_word),
        .src         (cmd_src),
        .dst         (cmd_dst),
        .len_f       (cmd_len),
        .rows_f      (cmd_rows),
        .off_f       (cmd_rowoff),
        .consumed    (gen_consumed),
        .final_cmd   (gen_final)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign fire   = (state_q == ST_EMIT) && cmd_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_ok)                         state_d = ST_FAIL;
                    else if (req_fc && req_len == '0)    state_d = ST_DONE;
                    else                                 state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (cmd_ready && gen_final)              state_d = ST_DONE;
            end
            ST_FAIL:                                     state_d = ST_IDLE;
            ST_DONE:                                     state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            mem_q     <= '0;
            per_q     <= '0;
            m2p_q     <= 1'b0;
            fc_q      <= 1'b0;
            burst_q   <= '0;
            chan_q    <= '0;
            last_q    <= 1'b0;
            blk_q     <= '0;
            boxes_q   <= '0;
            singles_q <= '0;
        end else if (accept) begin
            rem_q     <= req_len;
            mem_q     <= req_mem_addr;
            per_q     <= req_periph_addr;
            m2p_q     <= req_m2p;
            fc_q      <= req_fc;
            burst_q   <= req_burst;
            chan_q    <= req_chan[3:0];
            last_q    <= req_last;
            blk_q     <= req_blk;
            boxes_q   <= '0;
            singles_q <= '0;
        end else if (fire) begin
            rem_q <= rem_q - gen_consumed;
            mem_q <= mem_q + ADDR_W'(gen_consumed);
            if (gen_box) boxes_q   <= boxes_q + 1'b1;
            else         singles_q <= singles_q + 1'b1;
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        cmd_valid  = (state_q == ST_EMIT);
        err_pulse  = (state_q == ST_FAIL);
        done_pulse = (state_q == ST_DONE);
        cmd_box    = gen_box;
    end

    assign done_boxes   = boxes_q;
    assign done_singles = singles_q;
    assign done_blk     = blk_q;

endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
    parameter int ADDR_W  = 32,
    parameter int MAX_CNT = 65535
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_box,
    input logic [31:0]       cmd_word,
    input logic [ADDR_W-1:0] cmd_src,
    input logic [ADDR_W-1:0] cmd_dst,
    input logic [31:0]       cmd_len,
    input logic [31:0]       cmd_rows,
    input logic              err_pulse,
    input logic              done_pulse
);
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, err_pulse, done_pulse, req_ready})); // R11

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !cmd_valid && !done_pulse); // R1

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word) && $stable(cmd_src)
            && $stable(cmd_dst) && $stable(cmd_len) && $stable(cmd_rows)); // R11

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_word[31] |=> done_pulse); // R9

    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_box |-> cmd_len <= 32'(MAX_CNT) && cmd_rows == 32'd0); // R6

    AST_BOX_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_box |-> cmd_rows[31:16] == cmd_rows[15:0] && cmd_rows[15:0] != 16'd0
            && cmd_len[31:16] == cmd_len[15:0] && cmd_word[1:0] == 2'd3); // R3
endmodule

bind xfer_splitter xs_checker #(.ADDR_W(ADDR_W), .MAX_CNT(MAX_CNT)) u_xs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_box    (cmd_box),
    .cmd_word   (cmd_word),
    .cmd_src    (cmd_src),
    .cmd_dst    (cmd_dst),
    .cmd_len    (cmd_len),
    .cmd_rows   (cmd_rows),
    .err_pulse  (err_pulse),
    .done_pulse (done_pulse)
);

// File: tb/xfer_splitter_tb.sv
module xfer_splitter_tb;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;
    localparam int CHAN_W = 6;
    localparam int CNT_W  = 16;

    typedef struct packed {
        logic        box;
        logic [31:0] word;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic [31:0] rows;
        logic [31:0] off;
    } exp_cmd_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_mem_addr = '0;
    logic [ADDR_W-1:0] req_periph_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_m2p = 1'b0;
    logic [8:0]        req_burst = '0;
    logic              req_fc = 1'b0;
    logic [CHAN_W-1:0] req_chan = '0;
    logic              req_last = 1'b0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic              cmd_box;
    logic [31:0]       cmd_word;
    logic [ADDR_W-1:0] cmd_src;
    logic [ADDR_W-1:0] cmd_dst;
    logic [31:0]       cmd_len;
    logic [31:0]       cmd_rows;
    logic [31:0]       cmd_rowoff;
    logic              err_pulse;
    logic              done_pulse;
    logic [CNT_W-1:0]  done_boxes;
    logic [CNT_W-1:0]  done_singles;
    logic [2:0]        done_blk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xfer_splitter u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mem_addr(req_mem_addr), .req_periph_addr(req_periph_addr),
        .req_len(req_len), .req_m2p(req_m2p), .req_burst(req_burst),
        .req_fc(req_fc), .req_chan(req_chan), .req_last(req_last),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_box(cmd_box),
        .cmd_word(cmd_word), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .cmd_len(cmd_len), .cmd_rows(cmd_rows), .cmd_rowoff(cmd_rowoff),
        .err_pulse(err_pulse), .done_pulse(done_pulse),
        .done_boxes(done_boxes), .done_singles(done_singles), .done_blk(done_blk)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int blk_of(input int b);
        case (b)
            16: return 0; 32: return 1; 64: return 2;
            128: return 3; 192: return 4; 256: return 5;
            default: return -1;
        endcase
    endfunction

    // stall: 0 always ready, 1 irregular back-pressure
    task automatic run(input bit m2p, input bit fc, input int burst, input int chan,
                       input int mem, input int per, input int len, input bit last,
                       input bit stall, input string name);
        exp_cmd_t q[$];
        exp_cmd_t e;
        bit       exp_err;
        int       rem, addr, rows, take, nbox, nsing, blk, lo4;
        bit       seen_end;
        exp_err = 1'b0;
        blk = blk_of(burst);
        lo4 = chan % 16;
        if (fc && (blk < 0 || lo4 == 0 || chan > 31)) exp_err = 1'b1;
        nbox = 0; nsing = 0; rem = len; addr = mem;
        if (!exp_err) begin
            if (fc) begin
                while (rem >= burst) begin
                    rows = rem / burst;
                    if (rows > 65535) rows = 65535;
                    take = rows * burst;
                    e = '0;
                    e.box = 1'b1;
                    e.word[1:0] = 2'd3;
                    e.len = {16'(burst), 16'(burst)};
                    e.rows = {16'(rows), 16'(rows)};
                    e.off = m2p ? {16'(burst), 16'h0} : {16'h0, 16'(burst)};
                    e.src = m2p ? addr : per;
                    e.dst = m2p ? per : addr;
                    if (m2p) e.word[10:7] = 4'(lo4); else e.word[6:3] = 4'(lo4);
                    q.push_back(e);
                    nbox++;
                    rem -= take; addr += take;
                end
                if (rem > 0) begin
                    e = '0;
                    e.len = 32'(rem);
                    e.src = m2p ? addr : per;
                    e.dst = m2p ? per : addr;
                    if (m2p) e.word[10:7] = 4'(lo4); else e.word[6:3] = 4'(lo4);
                    q.push_back(e);
                    nsing++;
                end
            end else begin
                do begin
                    take = (rem > 65535) ? 65535 : rem;
                    e = '0;
                    e.len = 32'(take);
                    e.src = m2p ? addr : per;
                    e.dst = m2p ? per : addr;
                    q.push_back(e);
                    nsing++;
                    rem -= take; addr += take;
                end while (rem > 0);
            end
            if (last && q.size() > 0) q[q.size()-1].word[31] = 1'b1;
        end
        if (!fc) blk = 0;

        @(negedge clk);
        check(req_ready === 1'b1, {name, " R11 idle ready"}, 256'(req_ready), 256'(1));
        req_valid = 1'b1; req_m2p = m2p; req_fc = fc; req_burst = 9'(burst);
        req_chan = CHAN_W'(chan); req_mem_addr = mem; req_periph_addr = per;
        req_len = LEN_W'(len); req_last = last;
        @(negedge clk);
        req_valid = 1'b0;
        seen_end = 1'b0;
        for (int k = 0; k < 200 && !seen_end; k++) begin
            cmd_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (cmd_valid) begin
                if (exp_err || q.size() == 0) begin
                    check(1'b0, {name, " R1 R2 unexpected command"}, 256'(cmd_word), 256'(0));
                end else begin
                    e = q[0];
                    check(cmd_box === e.box && cmd_word === e.word,
                          {name, " R3 R5 R6 R8 R9 type/word"},
                          {cmd_box, cmd_word}, {e.box, e.word});
                    check(cmd_src === e.src && cmd_dst === e.dst, {name, " R7 addresses"},
                          {cmd_src, cmd_dst}, {e.src, e.dst});
                    check(cmd_len === e.len && cmd_rows === e.rows && cmd_rowoff === e.off,
                          {name, " R3 R4 R5 R6 len/rows/offset"},
                          {cmd_len, cmd_rows, cmd_rowoff}, {e.len, e.rows, e.off});
                    if (cmd_ready) void'(q.pop_front());
                end
            end
            if (err_pulse) begin
                check(exp_err, {name, " R1 R2 error pulse"}, 256'(1), 256'(exp_err));
                seen_end = 1'b1;
            end
            if (done_pulse) begin
                check(!exp_err && q.size() == 0, {name, " R10 done after all commands"},
                      256'(q.size()), 256'(0));
                check(int'(done_boxes) == nbox && int'(done_singles) == nsing
                      && int'(done_blk) == blk, {name, " R10 counts"},
                      {done_boxes, done_singles, 5'd0, done_blk},
                      {16'(nbox), 16'(nsing), 5'd0, 3'(blk)});
                seen_end = 1'b1;
            end
            if (!seen_end) @(negedge clk);
        end
        check(seen_end, {name, " R10 R1 end of request"}, 256'(seen_end), 256'(1));
        @(negedge clk);
        check(!cmd_valid && !err_pulse && !done_pulse && req_ready,
              {name, " R11 back to idle"},
              {cmd_valid, err_pulse, done_pulse, req_ready}, 256'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && cmd_valid === 1'b0 && err_pulse === 1'b0
              && done_pulse === 1'b0, "R12 reset state",
              {req_ready, cmd_valid, err_pulse, done_pulse}, 256'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && cmd_valid === 1'b0, "R12 after release",
              {req_ready, cmd_valid}, 256'b10);

        run(0, 1, 16,  5,  'h1000, 'hA000, 100,     1, 1, "p2m box+tail");
        run(1, 1, 192, 31, 'h2000, 'hB000, 1000,    0, 1, "m2p 192 tail");
        run(1, 1, 64,  3,  'h3000, 'hC000, 256,     1, 0, "m2p exact");
        run(0, 1, 32,  9,  'h3400, 'hC100, 320,     1, 1, "p2m exact");
        run(1, 1, 16,  2,  'h4000, 'hD000, 1120000, 1, 1, "R3 row cap");
        run(0, 0, 7,   0,  'h5000, 'hE000, 70000,   1, 1, "R6 capped singles");
        run(1, 0, 16,  0,  'h5100, 'hE100, 300,     0, 0, "R6 single");
        run(0, 0, 16,  0,  'h6000, 'hF000, 0,       1, 0, "R6 zero len");
        run(0, 1, 128, 17, 'h6100, 'hF100, 0,       1, 0, "R5 zero len fc");
        run(1, 1, 256, 12, 'h7000, 'hF200, 10,      1, 0, "R5 short tail");
        run(0, 1, 128, 17, 'h7100, 'hF300, 1000,    1, 1, "R8 chan 17");
        run(0, 1, 100, 5,  'h8000, 'h9000, 500,     1, 0, "R1 bad burst");
        run(1, 1, 16,  0,  'h8000, 'h9000, 500,     1, 0, "R2 chan zero");
        run(1, 1, 16,  16, 'h8000, 'h9000, 500,     1, 0, "R2 chan 16");
        run(0, 1, 16,  40, 'h8000, 'h9000, 500,     1, 0, "R2 chan 40");
        run(1, 1, 16,  4,  'h8800, 'h9800, 40,      1, 1, "after reject");

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule